// File: doc/BRIEF.md
# Trail trace identifier receiver

This block recovers a 16-byte trail access point identifier that a remote transmitter spreads across sixteen consecutive frames, one byte per frame in the trail trace overhead byte. A frame strobe qualifies each incoming byte. The most significant bit of a byte marks the start of a multiframe: the marker byte carries a 7-bit check value in its low bits, and the fifteen bytes after it are ASCII characters of a telephone-number style identifier.

Bytes are gathered into a staging array. The staging array is copied into sixteen readable identifier registers only when a whole multiframe has arrived, so software never sees a half-updated identifier. A sticky change flag raises an interrupt line when a completed identifier differs from the one already held. Software reads the identifier and the status through a byte-wide register port, and reading the status clears the flag. The receiving terminal uses this to confirm that it is still connected to the intended far end.

Top module: `tti_rx_top`

## Requirements
- R1: After reset every identifier register (addresses 0 to 15) and the status register (address 16) read 0, and `irq` is 0.
- R2: A strobed byte with bit 7 equal to 0 is ignored while no multiframe is in progress: before the first marker ever arrives, and after a multiframe has completed, until the next marker arrives.
- R3: A strobed byte with bit 7 equal to 1 is placed at position 0, and the next fifteen strobed bytes are placed at positions 1 to 15 in order of arrival. Identifier register address n returns position n.
- R4: The readable identifier registers change only when the sixteenth byte of a multiframe has arrived. While a multiframe is partly collected, reads return the previous identifier.
- R5: A marker byte that arrives before fifteen following bytes have been collected restarts the multiframe at position 0. The partial bytes are discarded.
- R6: `tr_byte` is ignored in any cycle where `frame_stb` is 0.
- R7: When a completed identifier differs from the stored one, bit 6 of the status register is set and `irq` goes to 1. The completion is visible to reads two clock cycles after the strobe of the last byte.
- R8: A completed identifier that equals the stored one leaves the change bit unchanged.
- R9: A read of the status register returns its value and clears the change bit. A change that is set in the same cycle wins over the clear. Status bits other than bit 6 read 0.
- R10: `rd_data` is loaded one clock cycle after `rd_en` is sampled high and holds while `rd_en` is 0. Addresses 17 to 31 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside the block |
| frame_stb | input | 1 | One-cycle strobe per received frame that qualifies `tr_byte` |
| tr_byte | input | 8 | Trail trace overhead byte of the current frame |
| rd_en | input | 1 | Register read request |
| rd_addr | input | 5 | Read address: 0 to 15 identifier bytes, 16 status |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Trail trace change interrupt, equal to status bit 6 |

## Verification
The assertions assume that `frame_stb` is a clean single-cycle qualifier and that register reads and frame strobes come from a synchronous source, so a status clear can only land in the same cycle as a completion when both really happen together. The stimulus drives every input on the falling clock edge and holds each strobe for exactly one cycle. Between strobes it parks a marker-like value on `tr_byte`, which proves that unstrobed bytes are ignored. Register reads are issued only after the two-cycle completion path has settled, so every expected value is fixed when it is sampled.

// File: rtl/tti_pkg.sv
package tti_pkg;
  localparam int TTI_LEN  = 16;
  localparam int TTI_BYTE = 8;
  localparam int TTI_CHG_BIT = 6;

  typedef enum logic {
    ST_HUNT    = 1'b0,
    ST_COLLECT = 1'b1
  } tti_state_e;
endpackage

// File: rtl/tti_rst_sync.sv
module tti_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/tti_align.sv
module tti_align
  import tti_pkg::*;
#(
  parameter int LEN = TTI_LEN,
  parameter int W   = TTI_BYTE,
  localparam int IW = $clog2(LEN)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stb_i,
  input  logic [W-1:0]   byte_i,
  output logic [LEN*W-1:0] stage_o,
  output logic           done_o
);
  tti_state_e state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [IW-1:0] wr_idx;
  logic          wr_ok;
  logic          done_q, done_d;
  logic          is_mark;
  logic [W-1:0]  stage_q [LEN];

  assign is_mark = byte_i[W-1];

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    wr_ok   = 1'b0;
    wr_idx  = idx_q;
    if (stb_i) begin
      if (is_mark) begin
        wr_ok   = 1'b1;
        wr_idx  = '0;
        idx_d   = IW'(1);
        state_d = ST_COLLECT;
      end else if (state_q == ST_COLLECT) begin
        wr_ok  = 1'b1;
        wr_idx = idx_q;
        if (idx_q == IW'(LEN - 1)) begin
          done_d  = 1'b1;
          idx_d   = '0;
          state_d = ST_HUNT;
        end else begin
          idx_d = idx_q + IW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
    end
  end

  for (genvar i = 0; i < LEN; i++) begin : g_stage
    logic en;
    assign en = wr_ok && (wr_idx == IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  stage_q[i] <= '0;
      else if (en) stage_q[i] <= byte_i;
    end
    assign stage_o[i*W +: W] = stage_q[i];
  end

  assign done_o = done_q;

  // R2
  hunt_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HUNT) && !(stb_i && is_mark) |=> (state_q == ST_HUNT) && $stable(stage_o) && !done_q);

  // R6
  nostb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_i |=> $stable(stage_o) && !done_q);

  // R3
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(stb_i) && !$past(byte_i[W-1]));

  // R5
  mark_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_i && is_mark |=> (stage_o[W-1:0] == $past(byte_i)) && !done_q);
endmodule

// File: rtl/tti_store.sv
module tti_store
  import tti_pkg::*;
#(
  parameter int LEN = TTI_LEN,
  parameter int W   = TTI_BYTE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_i,
  input  logic [LEN*W-1:0] stage_i,
  input  logic             clr_i,
  output logic [LEN*W-1:0] buf_o,
  output logic             chg_o
);
  logic [W-1:0] buf_q [LEN];
  logic         chg_q, chg_d;
  logic         differ;

  for (genvar i = 0; i < LEN; i++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      buf_q[i] <= '0;
      else if (done_i) buf_q[i] <= stage_i[i*W +: W];
    end
    assign buf_o[i*W +: W] = buf_q[i];
  end

  assign differ = (stage_i != buf_o);

  always_comb begin
    chg_d = chg_q;
    if (done_i && differ) chg_d = 1'b1;
    else if (clr_i)       chg_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chg_q <= 1'b0;
    else        chg_q <= chg_d;
  end

  assign chg_o = chg_q;

  // R7
  chg_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_q) |-> $past(done_i));

  // R4
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |=> $stable(buf_o));

  // R9
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !done_i |=> !chg_q);

  // R8
  same_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_i && (stage_i == buf_o) && !chg_q |=> !chg_q);
endmodule

// File: rtl/tti_regport.sv
module tti_regport
  import tti_pkg::*;
#(
  parameter int LEN = TTI_LEN,
  parameter int W   = TTI_BYTE,
  parameter int AW  = 5,
  parameter int CHG_BIT = TTI_CHG_BIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_addr_i,
  input  logic [LEN*W-1:0] buf_i,
  input  logic             chg_i,
  output logic [W-1:0]     rd_data_o,
  output logic             clr_o
);
  logic [W-1:0] rd_q, rd_d;
  logic [W-1:0] mux;
  logic [W-1:0] stat;
  logic [W-1:0] ent [LEN];

  for (genvar i = 0; i < LEN; i++) begin : g_ent
    assign ent[i] = buf_i[i*W +: W];
  end

  always_comb begin
    stat = '0;
    stat[CHG_BIT] = chg_i;
  end

  always_comb begin
    mux = '0;
    for (int i = 0; i < LEN; i++) begin
      if (rd_addr_i == AW'(i)) mux = ent[i];
    end
    if (rd_addr_i == AW'(LEN)) mux = stat;
  end

  always_comb begin
    rd_d = rd_q;
    if (rd_en_i) rd_d = mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rd_data_o = rd_q;
  assign clr_o     = rd_en_i && (rd_addr_i == AW'(LEN));

  // R10
  unused_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i && (rd_addr_i > AW'(LEN)) |=> rd_data_o == '0);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/tti_rx_top.sv
module tti_rx_top
  import tti_pkg::*;
#(
  parameter int TTI_N   = TTI_LEN,
  parameter int BYTE_W  = TTI_BYTE,
  parameter int CHG_POS = TTI_CHG_BIT,
  localparam int ADDR_W = $clog2(TTI_N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [BYTE_W-1:0] tr_byte,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              irq
);
  logic rst_sn;
  logic [TTI_N*BYTE_W-1:0] stage;
  logic [TTI_N*BYTE_W-1:0] bufs;
  logic done;
  logic chg;
  logic clr;

  tti_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  tti_align #(.LEN(TTI_N), .W(BYTE_W)) u_align (
    .clk     (clk),
    .rst_n   (rst_sn),
    .stb_i   (frame_stb),
    .byte_i  (tr_byte),
    .stage_o (stage),
    .done_o  (done)
  );

  tti_store #(.LEN(TTI_N), .W(BYTE_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_sn),
    .done_i  (done),
    .stage_i (stage),
    .clr_i   (clr),
    .buf_o   (bufs),
    .chg_o   (chg)
  );

  tti_regport #(.LEN(TTI_N), .W(BYTE_W), .AW(ADDR_W), .CHG_BIT(CHG_POS)) u_port (
    .clk       (clk),
    .rst_n     (rst_sn),
    .rd_en_i   (rd_en),
    .rd_addr_i (rd_addr),
    .buf_i     (bufs),
    .chg_i     (chg),
    .rd_data_o (rd_data),
    .clr_o     (clr)
  );

  assign irq = chg;

  // R1
  irq_reset_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(rst_sn) |-> !irq);
endmodule

// File: tb/sim_tti_rx_top.sv
module sim_tti_rx_top;
  logic       clk;
  logic       rst_n;
  logic       frame_stb;
  logic [7:0] tr_byte;
  logic       rd_en;
  logic [4:0] rd_addr;
  logic [7:0] rd_data;
  logic       irq;

  int checks;
  int failures;
  logic [7:0] got;

  // seed in bits 8:1, expected change flag in bit 0
  localparam logic [8:0] VEC [4] = '{
    {8'd3, 1'b1}, {8'd3, 1'b0}, {8'd9, 1'b1}, {8'd9, 1'b0}
  };

  tti_rx_top u0 (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .tr_byte(tr_byte),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] id_byte(input logic [7:0] seed, input int i);
    if (i == 0) return 8'h80 | seed;
    return 8'h41 + 8'((int'(seed) + i) % 26);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    frame_stb = 1'b1;
    tr_byte   = b;
    @(negedge clk);
    frame_stb = 1'b0;
    tr_byte   = 8'hC5; // R6: marker-like value without strobe must be ignored
  endtask

  task automatic send_id(input logic [7:0] seed);
    for (int i = 0; i < 16; i++) send_byte(id_byte(seed, i));
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en   = 1'b1;
    rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic check_id(input string tag, input logic [7:0] seed);
    logic [7:0] v;
    for (int i = 0; i < 16; i++) begin
      rd(5'(i), v);
      check(tag, v, id_byte(seed, i));
    end
  endtask

  initial begin
    #3000000;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; frame_stb = 1'b0; tr_byte = 8'h00; rd_en = 1'b0; rd_addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 irq", {7'd0, irq}, 8'h00);
    for (int a = 0; a <= 16; a++) begin
      rd(5'(a), got);
      check("R1 reg", got, 8'h00);
    end

    // R2: bytes before any marker are ignored
    for (int i = 0; i < 20; i++) send_byte(8'h41 + 8'(i));
    @(negedge clk);
    rd(5'd16, got);
    check("R2 status pre-marker", got, 8'h00);
    rd(5'd0, got);
    check("R2 buf0 pre-marker", got, 8'h00);

    // R3 R7 R8 R9: table of identifiers and expected change flags
    for (int k = 0; k < 4; k++) begin
      send_id(VEC[k][8:1]);
      @(negedge clk);
      check("R7 irq", {7'd0, irq}, {7'd0, VEC[k][0]});
      rd(5'd16, got);
      check("R8 status", got, VEC[k][0] ? 8'h40 : 8'h00);
      check("R9 irq cleared", {7'd0, irq}, 8'h00);
      check_id("R3 id", VEC[k][8:1]);
    end

    // R4: partial multiframe does not reach the readable registers
    send_byte(id_byte(8'd5, 0));
    for (int i = 1; i < 8; i++) send_byte(id_byte(8'd5, i));
    @(negedge clk);
    rd(5'd0, got);
    check("R4 buf0 old", got, id_byte(8'd9, 0));
    rd(5'd1, got);
    check("R4 buf1 old", got, id_byte(8'd9, 1));
    rd(5'd16, got);
    check("R4 status", got, 8'h00);

    // R5: new marker restarts collection at position 0
    send_id(8'd5);
    @(negedge clk);
    rd(5'd16, got);
    check("R5 status", got, 8'h40);
    check_id("R5 id", 8'd5);

    // R9: second status read returns cleared value
    rd(5'd16, got);
    check("R9 second read", got, 8'h00);

    // R2: bytes after completion ignored until next marker
    for (int i = 0; i < 15; i++) send_byte(8'h30 + 8'(i));
    send_byte(8'h7A);
    @(negedge clk);
    rd(5'd16, got);
    check("R2 status post", got, 8'h00);
    check_id("R2 id post", 8'd5);

    // R10: unused addresses read 0 and data holds without rd_en
    rd(5'd20, got);
    check("R10 addr20", got, 8'h00);
    rd(5'd31, got);
    check("R10 addr31", got, 8'h00);
    rd(5'd0, got);
    repeat (3) @(negedge clk);
    check("R10 hold", rd_data, id_byte(8'd5, 0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule